// File: doc/BRIEF.md
# Tone Duration Guard Timer

This block sits behind a dual-tone recogniser. The recogniser raises an early-steering level while it sees a valid tone pair. The block turns that raw level into a validated steering output. The output rises only after the early signal has stayed high for a full tone-present guard period. Once high, it falls only after the early signal has stayed low for a full tone-absent guard period. As a result, short bursts are rejected, short dropouts inside a digit are bridged, and real pauses between digits are still seen.

Time is measured in system clock cycles. At the nominal 4.194304 MHz clock, 2^22 cycles make one second. Both guard periods default to 30 ms, which is 125829 cycles. That value sits midway between the longest burst that must be rejected (20 ms) and the shortest one that must be accepted (40 ms). The same split holds for dropouts and pauses. The early-steering input passes through a short synchroniser first. A power-down level forces the output low and clears all timing.

Top module: `tdg_guard_timer`

## Requirements
- R1: While reset is high, and on the first clock edge after it is released, the steering output is low.
- R2: The early-steering input reaches the timing logic through SYNC_STAGES flops. All windows below count samples taken after that delay, so with the output low and the input held high from some edge onward, the output rises exactly PRESENT_CYC + SYNC_STAGES edges later.
- R3: With the output low, it rises at the edge where PRESENT_CYC consecutive synchronised samples have been high.
- R4: A synchronised high run shorter than PRESENT_CYC never raises the output. Any low sample restarts the present count from zero.
- R5: With the output high, it falls at the edge where ABSENT_CYC consecutive synchronised samples have been low. With the input held low from some edge, the fall comes ABSENT_CYC + SYNC_STAGES edges later.
- R6: A synchronised low run shorter than ABSENT_CYC while the output is high leaves the output high. Any high sample restarts the absent count from zero.
- R7: Power-down high forces the output low at the next edge and clears the guard count. After it is released, a complete new present period is needed before the output rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| early_steer | input | 1 | Raw tone-pair-present level from the recogniser |
| pwr_down | input | 1 | Synchronous power-down, active high |
| steer_valid | output | 1 | Registered delayed-steering output |

## Verification
The bench builds the block with PRESENT_CYC = 12, ABSENT_CYC = 9 and SYNC_STAGES = 2. These shortened windows bring exact-length, one-short and one-long bursts and dropouts within a few dozen cycles. They also make the two windows differ, so a swapped limit shows up. Random high and low runs that straddle both limits, mixed with power-down pulses, cover many restarts of the count inside each phase. Directed runs then pin the exact rise and fall latency, including the synchroniser delay.

// File: rtl/tdg_pkg.sv
package tdg_pkg;
  typedef enum logic [0:0] {
    ST_WAIT_TONE = 1'b0,
    ST_HOLD_TONE = 1'b1
  } tdg_state_t;
endpackage

// File: rtl/tdg_sync.sv
module tdg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic d_out
);
  generate
    if (STAGES == 0) begin : g_pass
      assign d_out = d_in;
    end else begin : g_chain
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-2+1-1:0], d_in} ;
      end
      assign d_out = sh[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/tdg_counter.sv
module tdg_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] limit,
  output logic [W-1:0] cnt,
  output logic         hit
);
  assign hit = en && !clr && (cnt == limit - W'(1));

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (hit)    cnt <= '0;
    else if (en)     cnt <= cnt + W'(1);
  end

  // R4 / R6: the running count never reaches the active window length
  assert_cnt_in_window_R4: assert property (@(posedge clk) disable iff (rst)
    cnt < limit);
endmodule

// File: rtl/tdg_fsm.sv
module tdg_fsm
  import tdg_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         es,
  input  logic         pd,
  input  logic         hit,
  output logic         cnt_en,
  output logic         cnt_clr,
  output logic         absent_phase,
  output logic         dst
);
  tdg_state_t state;

  always_comb begin
    if (state == ST_WAIT_TONE) begin
      cnt_en  = es;
      cnt_clr = pd || !es;
    end else begin
      cnt_en  = !es;
      cnt_clr = pd || es;
    end
  end

  assign absent_phase = (state == ST_HOLD_TONE);

  always_ff @(posedge clk) begin
    if (rst || pd)  state <= ST_WAIT_TONE;
    else if (hit)   state <= (state == ST_WAIT_TONE) ? ST_HOLD_TONE : ST_WAIT_TONE;
  end

  assign dst = (state == ST_HOLD_TONE);

  assert_low_after_reset_R1: assert property (@(posedge clk)
    rst |=> !dst);
  assert_pd_forces_low_R7: assert property (@(posedge clk) disable iff (rst)
    pd |=> !dst);
  assert_rise_needs_tone_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(dst) |-> $past(es) && !$past(pd));
  assert_fall_needs_gap_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(dst) |-> (!$past(es) || $past(pd)));
  assert_hold_on_tone_R6: assert property (@(posedge clk) disable iff (rst)
    (dst && es && !pd) |=> dst);
endmodule

// File: rtl/tdg_guard_timer.sv
module tdg_guard_timer #(
  parameter int CLK_HZ      = 4194304,
  parameter int PRESENT_CYC = CLK_HZ / 1000 * 30 + (CLK_HZ % 1000) * 30 / 1000,
  parameter int ABSENT_CYC  = PRESENT_CYC,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic early_steer,
  input  logic pwr_down,
  output logic steer_valid
);
  localparam int MAX_CYC = (PRESENT_CYC > ABSENT_CYC) ? PRESENT_CYC : ABSENT_CYC;
  localparam int W       = $clog2(MAX_CYC + 1);
  localparam logic [W-1:0] P_LIM = W'(PRESENT_CYC);
  localparam logic [W-1:0] A_LIM = W'(ABSENT_CYC);

  logic         es_s;
  logic         cnt_en, cnt_clr, hit, absent_phase;
  logic [W-1:0] cnt;
  logic [W-1:0] limit;

  tdg_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .d_in(early_steer), .d_out(es_s)
  );

  assign limit = absent_phase ? A_LIM : P_LIM;

  tdg_counter #(.W(W)) cnt_i (
    .clk(clk), .rst(rst), .clr(cnt_clr), .en(cnt_en),
    .limit(limit), .cnt(cnt), .hit(hit)
  );

  tdg_fsm #(.W(W)) fsm_i (
    .clk(clk), .rst(rst), .es(es_s), .pd(pwr_down), .hit(hit),
    .cnt_en(cnt_en), .cnt_clr(cnt_clr), .absent_phase(absent_phase),
    .dst(steer_valid)
  );

  // R3: a rise comes only out of a completed present window
  assert_rise_at_window_end_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(steer_valid) |-> $past(cnt) == P_LIM - W'(1));
endmodule

// File: tb/tdg_guard_timer_tb_top.sv
module tdg_guard_timer_tb_top;
  localparam int P    = 12;
  localparam int A    = 9;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic est = 1'b0;
  logic pd  = 1'b0;
  logic dst;

  int checks = 0;
  int errors = 0;
  string cur_tag = "R1";

  logic [SYNC-1:0] msh;
  logic mout;
  int   hi_run, lo_run;

  always #2 clk = ~clk;

  tdg_guard_timer #(.PRESENT_CYC(P), .ABSENT_CYC(A), .SYNC_STAGES(SYNC)) dut_i (
    .clk(clk), .rst(rst), .early_steer(est), .pwr_down(pd), .steer_valid(dst)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic void model_reset();
    msh = '0; mout = 1'b0; hi_run = 0; lo_run = 0;
  endfunction

  // Reference: run lengths of the delayed input decide rise and fall
  function automatic void model_edge(input logic e, input logic p);
    logic es_m;
    es_m = msh[SYNC-1];
    msh  = {msh[SYNC-2:0], e};
    if (p) begin
      mout = 1'b0; hi_run = 0; lo_run = 0;
    end else begin
      hi_run = es_m ? hi_run + 1 : 0;
      lo_run = es_m ? 0 : lo_run + 1;
      if (!mout && hi_run >= P) begin mout = 1'b1; lo_run = 0; end
      else if (mout && lo_run >= A) begin mout = 1'b0; hi_run = 0; end
    end
  endfunction

  task automatic step(input logic e, input logic p);
    est = e; pd = p;
    @(posedge clk);
    model_edge(e, p);
    @(negedge clk);
    chk(cur_tag, int'(dst), int'(mout));
  endtask

  task automatic run(input logic e, input int n);
    for (int i = 0; i < n; i++) step(e, 1'b0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    int k;
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (3) @(negedge clk);
    chk("R1 in reset", int'(dst), 0);
    rst = 1'b0;
    cur_tag = "R1";
    step(1'b0, 1'b0);
    chk("R1 after release", int'(dst), 0);
    run(1'b0, 4);

    // R4: high run one short of the window is rejected
    cur_tag = "R4";
    run(1'b1, P - 1); run(1'b0, SYNC + 3);
    chk("R4 short burst", int'(dst), 0);
    // R4: a one-cycle gap restarts the count
    run(1'b1, P - 2); run(1'b0, 1); run(1'b1, P - 2); run(1'b0, SYNC + 2);
    chk("R4 restart on gap", int'(dst), 0);

    // R2/R3: exact rise latency
    cur_tag = "R3";
    k = 0;
    while (dst == 1'b0 && k < 4 * P) begin step(1'b1, 1'b0); k++; end
    chk("R2 R3 rise latency", k, P + SYNC);

    // R6: dropout one short of absent window is bridged
    cur_tag = "R6";
    run(1'b0, A - 1); run(1'b1, SYNC + 2);
    chk("R6 dropout bridged", int'(dst), 1);
    run(1'b0, A - 2); run(1'b1, 1); run(1'b0, A - 2); run(1'b1, SYNC + 1);
    chk("R6 restart of absent count", int'(dst), 1);

    // R5: exact fall latency
    cur_tag = "R5";
    k = 0;
    while (dst == 1'b1 && k < 4 * A) begin step(1'b0, 1'b0); k++; end
    chk("R5 fall latency", k, A + SYNC);

    // R7: power-down forces low and clears progress
    cur_tag = "R7";
    run(1'b1, P + SYNC + 1);
    chk("R7 pre power-down high", int'(dst), 1);
    step(1'b1, 1'b1);
    chk("R7 low in power-down", int'(dst), 0);
    run(1'b1, P - 1);
    chk("R7 fresh window needed", int'(dst), 0);
    run(1'b1, 1);
    chk("R7 rise after full window", int'(dst), 1);
    run(1'b0, A + SYNC + 2);

    // Random runs straddling both windows, with power-down pulses
    cur_tag = "R3 R4 R5 R6 R7 random";
    for (int s = 0; s < 500; s++) begin
      int len;
      logic lvl;
      lvl = s[0];
      len = 1 + int'($urandom_range(2 * P));
      for (int i = 0; i < len; i++) begin
        logic p;
        p = ($urandom_range(199) == 0);
        step(lvl, p);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule